// File: doc/BRIEF.md
# Prioritized Interrupt Source Expander

This block gathers a group of peripheral interrupt sources, all belonging to one interrupt level, and combines them into the single interrupt line that level has into the core. Each source owns a small control register with two bits. One is a pending flag, which a request pulse sets and which stays set until software clears it. The other is an enable bit. A source takes part in arbitration only while both of its bits are set.

Priority among the sources is fixed. Source index 0 has the highest priority, and priority falls as the index rises. A small two-state machine drives the core line. It raises the line while any enabled flag is pending and lowers it when none remains. The encoded index of the current winner is always visible. When the core acknowledges, that index is captured into a register and held there until the next acknowledge, so the service routine can read which source it is handling.

The machine has two states. `ST_QUIET` means the core line is low, and `ST_RAISED` means it is high. The transition `raise` goes from QUIET to RAISED when an enabled flag is pending. The transition `drop` goes from RAISED to QUIET when no enabled flag remains. In every other case the machine stays in its current state: `hold_quiet` and `hold_raised`.

Top module: `irqx_level_expander`

## Requirements
- R1: After reset, every flag and every enable bit is 0, `core_irq` is 0, `ack_id` is 0 and `pend_valid` is 0.
- R2: When `src_req[i]` is high at a clock edge, flag i reads 1 after that edge, whatever the value of enable bit i. While enable bit i is 0, flag i stays latched and has no effect on `core_irq`.
- R3: A write to the clear register (`clr_wr` high) clears every flag whose `clr_data` bit is 1. Flags whose `clr_data` bit is 0 are left unchanged.
- R4: If a request and a clear reach the same flag in the same cycle, the request wins and the flag stays 1.
- R5: A write to the enable register (`en_wr` high) loads all enable bits from `en_data` at that edge. Without a write, the enable bits hold their value.
- R6: `core_irq` is 1 in the cycle after a cycle in which some source has both its flag and its enable bit set. It is 0 in the cycle after a cycle in which no source does.
- R7: `pend_valid` is 1 exactly when some source has both its flag and its enable bit set. `pend_id` is then the lowest such index, since index 0 has the highest priority.
- R8: When `core_ack` is high at an edge while `core_irq` and `pend_valid` are both 1, `ack_id` takes the value of `pend_id` from that cycle.
- R9: At any other edge, including an acknowledge that arrives while `core_irq` is 0, `ack_id` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Request pulses from the sources; each pulse sets that source's flag |
| en_wr | input | 1 | Write strobe for the enable register |
| en_data | input | NUM_SRC | New enable bits, loaded when `en_wr` is high |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_data | input | NUM_SRC | Write-1-to-clear mask for the flags |
| core_ack | input | 1 | Acknowledge from the core |
| flag_state | output | NUM_SRC | Current pending flags |
| en_state | output | NUM_SRC | Current enable bits |
| pend_valid | output | 1 | At least one source has both its flag and its enable bit set |
| pend_id | output | ID_W | Index of the current winning source |
| core_irq | output | 1 | Interrupt line to the core |
| ack_id | output | ID_W | Winner index captured at the last acknowledge |

## Verification
The hardest cases to produce from the ports are coincidences. One is a request that lands in the same cycle as a write-1-to-clear of the same flag. Another is an acknowledge that arrives just as the pending set changes, or while the line is still low. Random stimulus makes these events likely on purpose. It uses frequent clear writes with random masks, sparse request pulses and acknowledges on about a third of the cycles. Directed steps also force each coincidence once. A bench model updates at every edge and is compared against all outputs after every step.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } line_state_t;
endpackage

// File: rtl/irqx_src_cell.sv
module irqx_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic en_wr,
    input  logic en_bit,
    input  logic clr_hit,
    output logic flag_q,
    output logic en_q
);
    // a request in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (req) begin
            flag_q <= 1'b1;
        end else if (clr_hit) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_bit;
        end
    end

    assert_req_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> flag_q);
    assert_clear_drops_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !req) |=> !flag_q);
    assert_req_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && req) |=> flag_q);
    assert_enable_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == $past(en_bit)));
    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q));
endmodule

// File: rtl/irqx_prio_enc.sv
module irqx_prio_enc #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 3
) (
    input  logic [NUM_SRC-1:0] active,
    output logic               any,
    output logic [ID_W-1:0]    win_id
);
    // scan from the lowest priority upward, so index 0 is assigned last and wins
    always_comb begin
        any    = 1'b0;
        win_id = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                any    = 1'b1;
                win_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqx_line_fsm.sv
module irqx_line_fsm
    import irqx_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_pend,
    input  logic [ID_W-1:0] win_id,
    input  logic            core_ack,
    output logic            core_irq,
    output logic [ID_W-1:0] ack_id
);
    line_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_pend)  state_d = ST_RAISED; // raise
            ST_RAISED: if (!any_pend) state_d = ST_QUIET;  // drop
            default:   state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        core_irq = (state_q == ST_RAISED);
    end

    logic take_id;
    assign take_id = core_ack && (state_q == ST_RAISED) && any_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_id <= '0;
        end else if (take_id) begin
            ack_id <= win_id;
        end
    end

    assert_line_follows_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> core_irq);
    assert_line_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !core_irq);
    assert_ack_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && core_irq && any_pend) |=> (ack_id == $past(win_id)));
    assert_ack_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ack && core_irq && any_pend) |=> $stable(ack_id));
endmodule

// File: rtl/irqx_level_expander.sv
module irqx_level_expander #(
    parameter int NUM_SRC = 8,
    localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               en_wr,
    input  logic [NUM_SRC-1:0] en_data,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_data,
    input  logic               core_ack,
    output logic [NUM_SRC-1:0] flag_state,
    output logic [NUM_SRC-1:0] en_state,
    output logic               pend_valid,
    output logic [ID_W-1:0]    pend_id,
    output logic               core_irq,
    output logic [ID_W-1:0]    ack_id
);
    logic [NUM_SRC-1:0] active;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqx_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (src_req[g]),
            .en_wr   (en_wr),
            .en_bit  (en_data[g]),
            .clr_hit (clr_wr && clr_data[g]),
            .flag_q  (flag_state[g]),
            .en_q    (en_state[g])
        );
    end

    assign active = flag_state & en_state;

    irqx_prio_enc #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_enc (
        .active (active),
        .any    (pend_valid),
        .win_id (pend_id)
    );

    irqx_line_fsm #(.ID_W(ID_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (pend_valid),
        .win_id   (pend_id),
        .core_ack (core_ack),
        .core_irq (core_irq),
        .ack_id   (ack_id)
    );

    assert_winner_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> active[pend_id]);
    assert_winner_highest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((active & ((NUM_SRC'(1) << pend_id) - NUM_SRC'(1))) == '0));
    assert_valid_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid == (active != '0));
endmodule

// File: tb/irqx_level_expander_tb.sv
module irqx_level_expander_tb;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0, en_data = '0, clr_data = '0;
    logic          en_wr = 1'b0, clr_wr = 1'b0, core_ack = 1'b0;
    logic [N-1:0]  flag_state, en_state;
    logic          pend_valid, core_irq;
    logic [IW-1:0] pend_id, ack_id;

    int n_chk = 0, n_bad = 0;
    logic [N-1:0]  m_flag = '0, m_en = '0;
    logic          m_irq = 1'b0;
    logic [IW-1:0] m_ack = '0;

    always #5 clk = ~clk;

    irqx_level_expander #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .en_wr(en_wr), .en_data(en_data),
        .clr_wr(clr_wr), .clr_data(clr_data), .core_ack(core_ack),
        .flag_state(flag_state), .en_state(en_state), .pend_valid(pend_valid),
        .pend_id(pend_id), .core_irq(core_irq), .ack_id(ack_id)
    );

    function automatic logic has_pend(logic [N-1:0] f, logic [N-1:0] e);
        return (f & e) != '0;
    endfunction

    function automatic logic [IW-1:0] top_id(logic [N-1:0] f, logic [N-1:0] e);
        logic [N-1:0] a = f & e;
        for (int i = 0; i < N; i++) if (a[i]) return IW'(i);
        return '0;
    endfunction

    task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(flag_state == m_flag, "R2/R3/R4 flags", flag_state, m_flag);
        chk(en_state == m_en, "R5 enables", en_state, m_en);
        chk(core_irq == m_irq, "R6 core_irq", core_irq, m_irq);
        chk(pend_valid == has_pend(m_flag, m_en), "R7 pend_valid", pend_valid, has_pend(m_flag, m_en));
        if (has_pend(m_flag, m_en))
            chk(pend_id == top_id(m_flag, m_en), "R7 pend_id", pend_id, top_id(m_flag, m_en));
        chk(ack_id == m_ack, "R8/R9 ack_id", ack_id, m_ack);
    endtask

    // apply current inputs over one edge, update the model, then compare
    task automatic step();
        logic [N-1:0] nf;
        @(posedge clk);
        if (core_ack && m_irq && has_pend(m_flag, m_en)) m_ack = top_id(m_flag, m_en);
        m_irq = has_pend(m_flag, m_en);
        nf = m_flag & ~(clr_wr ? clr_data : '0);
        m_flag = nf | src_req;
        if (en_wr) m_en = en_data;
        #1;
        compare_all();
        src_req = '0; en_wr = 1'b0; clr_wr = 1'b0; core_ack = 1'b0;
    endtask

    initial begin
        #200000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(flag_state == '0 && en_state == '0, "R1 regs zero", {flag_state, en_state}, 0);
        chk(core_irq == 1'b0 && pend_valid == 1'b0, "R1 line low", {core_irq, pend_valid}, 0);
        chk(ack_id == '0, "R1 ack_id", ack_id, 0);
        rst_n = 1'b1;
        step();

        // R2 flag latches with enable 0, line stays low
        src_req = 8'b0010_0000; step();
        step();
        chk(core_irq == 1'b0, "R2 disabled flag no irq", core_irq, 0);
        // R9 ack while line low ignored
        core_ack = 1'b1; step();
        // R5 enable makes it compete, R6 raise
        en_wr = 1'b1; en_data = 8'hFF; step();
        step();
        chk(core_irq == 1'b1, "R6 raised", core_irq, 1);
        // R7 higher priority arrives
        src_req = 8'b0000_0100; step();
        chk(pend_id == 3'd2, "R7 index 2 wins", pend_id, 2);
        // R8 ack captures
        core_ack = 1'b1; step();
        chk(ack_id == 3'd2, "R8 captured", ack_id, 2);
        // R4 clear and request together
        clr_wr = 1'b1; clr_data = 8'b0000_0100; src_req = 8'b0000_0100; step();
        chk(flag_state[2] == 1'b1, "R4 request wins", flag_state[2], 1);
        // R3 clear with zero bits leaves others
        clr_wr = 1'b1; clr_data = 8'b0000_0100; step();
        chk(flag_state == 8'b0010_0000, "R3 selective clear", flag_state, 8'b0010_0000);
        clr_wr = 1'b1; clr_data = 8'hFF; step();
        step();
        chk(core_irq == 1'b0, "R6 dropped", core_irq, 0);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            for (int b = 0; b < N; b++) src_req[b] = ($urandom % 10) == 0;
            clr_wr   = ($urandom % 3) == 0;
            clr_data = N'($urandom);
            en_wr    = ($urandom % 12) == 0;
            en_data  = N'($urandom);
            core_ack = ($urandom % 3) == 0;
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule